// File: doc/BRIEF.md
# Predicated Execute and Condition Flag Unit

This unit decides, one instruction at a time, whether the instruction in the execute stage takes effect. It reads a 4-bit condition code that comes with the instruction and tests it against the four architectural status flags: negative, zero, carry and overflow. The flags are held in a register inside the unit. The result is an execute-enable signal. The unit also gates the register-file write request with that enable.

The unit also owns the flag register. An instruction may carry new flag values from the ALU. Those values are committed on the next rising clock edge only if three things are true: the instruction is valid, its condition passed, and it is either a comparison or has its set-flags bit asserted. Comparisons never write a register. The next instruction sees the committed flags in the following cycle, so back-to-back compare-then-predicate sequences work without stalls.

Top module: `cfu_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the flag register is cleared, and flags_o reads 4'b0000 on the following cycle. flags_o bit order is {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R2: Code 4'b0000 passes when Z=1. Code 4'b0001 passes when Z=0.
- R3: Code 4'b0010 passes when C=1. Code 4'b0011 passes when C=0.
- R4: Code 4'b0100 passes when N=1 and 4'b0101 when N=0. Code 4'b0110 passes when V=1 and 4'b0111 when V=0.
- R5: Code 4'b1000 passes when C=1 and Z=0. Code 4'b1001 passes when C=0 or Z=1.
- R6: Code 4'b1010 passes when N equals V. Code 4'b1011 passes when N differs from V.
- R7: Code 4'b1100 passes when Z=0 and N equals V. Code 4'b1101 passes when Z=1 or N differs from V.
- R8: Code 4'b1110 always passes and code 4'b1111 never passes. exec_o is high only when valid_i is high and the condition passes.
- R9: A valid, passing instruction with set_flags_i=1 loads alu_flags_i into the flag register at the next rising edge. From the next cycle, flags_o and the condition test use the new value.
- R10: A valid, passing comparison (is_cmp_i=1) commits alu_flags_i even when set_flags_i=0.
- R11: The flag register keeps its value in three cases: a non-comparison with set_flags_i=0, an instruction whose condition fails, and a cycle with valid_i=0.
- R12: reg_we_o is high exactly when exec_o is high, wr_req_i is high and is_cmp_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | An instruction is present in the execute stage |
| cond_i | input | 4 | Condition code of the instruction |
| is_cmp_i | input | 1 | Instruction is a comparison (flags only, no register result) |
| set_flags_i | input | 1 | Set-flags bit of the instruction |
| wr_req_i | input | 1 | Instruction requests a register-file write |
| alu_flags_i | input | 4 | New {N,Z,C,V} values from the ALU |
| exec_o | output | 1 | Instruction executes |
| reg_we_o | output | 1 | Gated register-file write enable |
| flags_o | output | 4 | Current committed {N,Z,C,V} |

## Verification
The bench builds the unit with its default parameters: a 4-bit condition code and four flags. With these defaults the condition space has only 16 codes and 16 flag states, so the bench sweeps every pair of code and flag value, reaching each flag state by committing it through an always-pass instruction. It then checks the cycle in which commits become visible. It also checks every gating path of the flag write and the register write enable: failed condition, no set-flags bit, idle cycle, and comparison.

// File: rtl/cfu_pkg.sv
// Package: shared types for the condition/flag unit.
// Assumes flags are ordered {N,Z,C,V}, MSB first.
package cfu_pkg;

    localparam int COND_W = 4;
    localparam int FLAG_W = 4;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'b0000, CC_NE = 4'b0001,
        CC_CS = 4'b0010, CC_CC = 4'b0011,
        CC_MI = 4'b0100, CC_PL = 4'b0101,
        CC_VS = 4'b0110, CC_VC = 4'b0111,
        CC_HI = 4'b1000, CC_LS = 4'b1001,
        CC_GE = 4'b1010, CC_LT = 4'b1011,
        CC_GT = 4'b1100, CC_LE = 4'b1101,
        CC_AL = 4'b1110, CC_NV = 4'b1111
    } cond_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/cfu_cond_eval.sv
// Module: cfu_cond_eval
// Evaluates a condition code against the flags. The codes come in pairs:
// the upper bits pick a base test, and the lowest bit inverts it. The last
// pair's base test is "true", so its inverted form is "never".
// Assumes: purely combinational, flags already registered upstream.
module cfu_cond_eval
    import cfu_pkg::*;
#(
    parameter int CODE_W = COND_W
) (
    input  nzcv_t             flags,
    input  logic [CODE_W-1:0] code,
    output logic              pass
);
    localparam int NUM_PAIRS = 1 << (CODE_W - 1);
    localparam int SEL_W     = CODE_W - 1;

    logic [NUM_PAIRS-1:0] base_hit;
    logic                 n_eq_v;

    // Shared signed-compare term used by several pairs.
    assign n_eq_v = (flags.n == flags.v);

    // One base test per pair; pairs beyond the defined set pass.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        always_comb begin
            // Base test for pair p.
            case (p)
                0:       base_hit[p] = flags.z;
                1:       base_hit[p] = flags.c;
                2:       base_hit[p] = flags.n;
                3:       base_hit[p] = flags.v;
                4:       base_hit[p] = flags.c & ~flags.z;
                5:       base_hit[p] = n_eq_v;
                6:       base_hit[p] = ~flags.z & n_eq_v;
                default: base_hit[p] = 1'b1;
            endcase
        end
    end

    // Select the pair and apply the inversion bit.
    always_comb begin
        pass = base_hit[code[CODE_W-1 -: SEL_W]] ^ code[0];
    end

endmodule

// File: rtl/cfu_commit_ctl.sv
// Module: cfu_commit_ctl
// Turns the condition result and the instruction attributes into the
// execute enable, the flag-commit enable and the gated register write.
// Assumes: all inputs belong to the same instruction in the same cycle.
module cfu_commit_ctl (
    input  logic valid,
    input  logic cond_pass,
    input  logic is_cmp,
    input  logic set_flags,
    input  logic wr_req,
    output logic exec,
    output logic flag_we,
    output logic reg_we
);
    // Combine gating terms; a comparison never writes a register.
    always_comb begin
        exec    = valid & cond_pass;
        flag_we = exec & (is_cmp | set_flags);
        reg_we  = exec & wr_req & ~is_cmp;
    end

endmodule

// File: rtl/cfu_flag_reg.sv
// Module: cfu_flag_reg
// Status flag register with load enable and synchronous active-low reset.
// Assumes: reset value is all zeros.
module cfu_flag_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold flags; load new values when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/cfu_top.sv
// Module: cfu_top
// Predicated execute and flag unit. It tests cond_i against the registered
// flags, drives the execute and register write enables, and commits ALU
// flags for executing comparisons or set-flags instructions.
// Assumes: one instruction per cycle, flags visible one cycle after commit.
module cfu_top
    import cfu_pkg::*;
#(
    parameter int CW = COND_W,
    parameter int FW = FLAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [CW-1:0] cond_i,
    input  logic          is_cmp_i,
    input  logic          set_flags_i,
    input  logic          wr_req_i,
    input  logic [FW-1:0] alu_flags_i,
    output logic          exec_o,
    output logic          reg_we_o,
    output logic [FW-1:0] flags_o
);
    logic  [FW-1:0] flags_q;
    nzcv_t          flags_s;
    logic           cond_pass;
    logic           flag_we;

    // Present the stored flags as a typed struct to the evaluator.
    assign flags_s = nzcv_t'(flags_q);
    assign flags_o = flags_q;

    cfu_cond_eval #(.CODE_W(CW)) u_eval (
        .flags (flags_s),
        .code  (cond_i),
        .pass  (cond_pass)
    );

    cfu_commit_ctl u_ctl (
        .valid     (valid_i),
        .cond_pass (cond_pass),
        .is_cmp    (is_cmp_i),
        .set_flags (set_flags_i),
        .wr_req    (wr_req_i),
        .exec      (exec_o),
        .flag_we   (flag_we),
        .reg_we    (reg_we_o)
    );

    cfu_flag_reg #(.W(FW)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_we),
        .d     (alu_flags_i),
        .q     (flags_q)
    );

endmodule

// File: rtl/cfu_checker.sv
// Module: cfu_checker
// Temporal checks on the port behaviour of cfu_top. It is bound to every
// instance of the top module.
module cfu_checker #(
    parameter int CW = 4,
    parameter int FW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic [CW-1:0] cond_i,
    input logic          is_cmp_i,
    input logic          set_flags_i,
    input logic          wr_req_i,
    input logic [FW-1:0] alu_flags_i,
    input logic          exec_o,
    input logic          reg_we_o,
    input logic [FW-1:0] flags_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> flags_o == '0); // R1

    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i == {CW{1'b1}} |-> !exec_o); // R8

    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cond_i == {{(CW-1){1'b1}}, 1'b0}) |-> exec_o); // R8

    AST_IDLE_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> !exec_o && !reg_we_o); // R8

    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && (is_cmp_i || set_flags_i)) |=> flags_o == $past(alu_flags_i)); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_o && (is_cmp_i || set_flags_i)) |=> $stable(flags_o)); // R11

    AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> exec_o && wr_req_i && !is_cmp_i); // R12

    AST_WE_GIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && wr_req_i && !is_cmp_i) |-> reg_we_o); // R12

endmodule

bind cfu_top cfu_checker #(.CW(CW), .FW(FW)) i_cfu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .cond_i      (cond_i),
    .is_cmp_i    (is_cmp_i),
    .set_flags_i (set_flags_i),
    .wr_req_i    (wr_req_i),
    .alu_flags_i (alu_flags_i),
    .exec_o      (exec_o),
    .reg_we_o    (reg_we_o),
    .flags_o     (flags_o)
);

// File: tb/test_cfu_top.sv
// Directed bench for cfu_top. Inputs change at the falling edge and
// outputs are sampled a little after it.
module test_cfu_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [3:0] cond_i = 4'hE;
    logic       is_cmp_i = 1'b0;
    logic       set_flags_i = 1'b0;
    logic       wr_req_i = 1'b0;
    logic [3:0] alu_flags_i = 4'h0;
    logic       exec_o;
    logic       reg_we_o;
    logic [3:0] flags_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    cfu_top i_cfu_top (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_i(cond_i),
        .is_cmp_i(is_cmp_i), .set_flags_i(set_flags_i), .wr_req_i(wr_req_i),
        .alu_flags_i(alu_flags_i), .exec_o(exec_o), .reg_we_o(reg_we_o),
        .flags_o(flags_o)
    );

    // Reference condition table, written from the requirements. f = {N,Z,C,V}.
    function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy && !z;
            4'h9: return !cy || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h0, 4'h1: return "R2";
            4'h2, 4'h3: return "R3";
            4'h4, 4'h5, 4'h6, 4'h7: return "R4";
            4'h8, 4'h9: return "R5";
            4'hA, 4'hB: return "R6";
            4'hC, 4'hD: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        valid_i = 1'b0; is_cmp_i = 1'b0; set_flags_i = 1'b0;
        wr_req_i = 1'b0; cond_i = 4'hE; alu_flags_i = 4'h0;
    endtask

    // Commit a flag value through an always-pass set-flags instruction.
    task automatic load_flags(input logic [3:0] f);
        @(negedge clk);
        valid_i = 1'b1; cond_i = 4'hE; set_flags_i = 1'b1; alu_flags_i = f;
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle();
        @(negedge clk); @(negedge clk);
        #1;
        check("R1", "flags after reset", flags_o, 4'h0);
        check("R8", "exec idle in reset", {3'b0, exec_o}, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_all_conditions();
        for (int f = 0; f < 16; f++) begin
            load_flags(4'(f));
            check("R9", "flags loaded", flags_o, 4'(f));
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                valid_i = 1'b1; cond_i = 4'(c);
                #1;
                check(req_of(4'(c)), $sformatf("cond %h flags %h", c, f),
                      {3'b0, exec_o}, {3'b0, ref_pass(4'(c), 4'(f))});
            end
            @(negedge clk);
            idle();
        end
    endtask

    task automatic t_set_flags_timing();
        load_flags(4'h0);
        @(negedge clk);
        valid_i = 1'b1; cond_i = 4'hE; set_flags_i = 1'b1; alu_flags_i = 4'h4;
        #1;
        check("R9", "old flags before edge", flags_o, 4'h0);
        check("R9", "EQ before commit", {3'b0, (ref_pass(4'h0, flags_o))}, 4'h0);
        @(negedge clk);
        set_flags_i = 1'b0; cond_i = 4'h0; alu_flags_i = 4'h0;
        #1;
        check("R9", "flags next cycle", flags_o, 4'h4);
        check("R9", "EQ sees new Z", {3'b0, exec_o}, 4'h1);
        @(negedge clk);
        idle();
    endtask

    task automatic t_compare();
        load_flags(4'h0);
        @(negedge clk);
        valid_i = 1'b1; cond_i = 4'hE; is_cmp_i = 1'b1; set_flags_i = 1'b0;
        wr_req_i = 1'b1; alu_flags_i = 4'hA;
        #1;
        check("R12", "compare no reg write", {3'b0, reg_we_o}, 4'h0);
        @(negedge clk);
        idle();
        #1;
        check("R10", "compare commits", flags_o, 4'hA);
    endtask

    task automatic t_no_update();
        load_flags(4'h3);
        // No set-flags bit, not a comparison.
        @(negedge clk);
        valid_i = 1'b1; cond_i = 4'hE; alu_flags_i = 4'hC; wr_req_i = 1'b1;
        #1;
        check("R12", "plain op writes reg", {3'b0, reg_we_o}, 4'h1);
        @(negedge clk);
        idle();
        #1;
        check("R11", "no S bit holds flags", flags_o, 4'h3);
        // Failing condition (EQ with Z=0) on a set-flags compare.
        @(negedge clk);
        valid_i = 1'b1; cond_i = 4'h0; is_cmp_i = 1'b1; set_flags_i = 1'b1;
        wr_req_i = 1'b1; alu_flags_i = 4'hF;
        #1;
        check("R8", "EQ fails", {3'b0, exec_o}, 4'h0);
        check("R12", "fail no reg write", {3'b0, reg_we_o}, 4'h0);
        @(negedge clk);
        idle();
        #1;
        check("R11", "failed cond holds flags", flags_o, 4'h3);
        // Never code with set flags.
        @(negedge clk);
        valid_i = 1'b1; cond_i = 4'hF; set_flags_i = 1'b1; wr_req_i = 1'b1;
        alu_flags_i = 4'h8;
        #1;
        check("R12", "never no reg write", {3'b0, reg_we_o}, 4'h0);
        @(negedge clk);
        idle();
        #1;
        check("R11", "never code holds flags", flags_o, 4'h3);
        // Idle cycle with set flags.
        @(negedge clk);
        valid_i = 1'b0; cond_i = 4'hE; set_flags_i = 1'b1; is_cmp_i = 1'b1;
        wr_req_i = 1'b1; alu_flags_i = 4'h9;
        #1;
        check("R8", "idle no exec", {3'b0, exec_o}, 4'h0);
        check("R12", "idle no reg write", {3'b0, reg_we_o}, 4'h0);
        @(negedge clk);
        idle();
        #1;
        check("R11", "idle holds flags", flags_o, 4'h3);
    endtask

    task automatic t_reset_midrun();
        load_flags(4'hF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1", "reset clears loaded flags", flags_o, 4'h0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_all_conditions();
        t_set_flags_timing();
        t_compare();
        t_no_update();
        t_reset_midrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule